// File: doc/BRIEF.md
# Seconds Counter with Alarm

This block keeps time as a 47-bit count that advances once for each pulse of a 32.768 kHz tick strobe, which is synchronous to the block clock. Software sees the count as two registers: the upper 32 bits are whole seconds and the lower 15 bits are the fraction of a second. A 47-bit alarm compare value raises a sticky alarm flag at the moment the count steps onto it. The alarm can drive an interrupt line through an enable bit. A wrap of the full count raises an overflow flag and stops the counter.

Counting needs four things at once: the enable bit set, the overflow flag clear, the non-valid flag clear, and no freeze request from the security supervisor. After a non-valid event, the seconds register must also be written before the count moves again. Two sticky lock bits protect the time: either one blocks writes to the seconds and fraction registers, and the hard one also pins the enable bit. Software parks an unused alarm by loading all ones into its seconds field, a value the count does not reach in practice.

Registers are written through a single-cycle write strobe with a byte address. They are read back combinationally on the same address.

Top module: `rtc_seconds_alarm`

## Requirements
- R1: After reset: seconds = 0, fraction = 0, alarm seconds = 0xFFFFFFFF, alarm fraction = 0, control = 0, interrupt enable = 0, and status = 0x2 (non-valid flag set). The interrupt is low.
- R2: A tick advances the count by one only when control bit 3 (enable) is set, freeze is low, status bit 2 (overflow) is clear and status bit 1 (non-valid) is clear. A non_valid_set pulse sets status bit 1.
- R3: After reset or a non_valid_set pulse, the count holds until an accepted write to the seconds register at address 0x00, even when every other counting condition is met.
- R4: The fraction register (address 0x04) holds count bits 14:0, and the seconds register holds bits 46:15. A tick at fraction 0x7FFF carries into the seconds. A register write in the same cycle as a tick takes the written value, and the tick is lost.
- R5: Control bit 17 (soft lock) and bit 18 (hard lock) can be set but not cleared, except by reset. While either lock is set, writes to 0x00 and 0x04 are ignored. While bit 18 is set, control bit 3 keeps its value.
- R6: A tick that brings the count equal to {alarm seconds at 0x08, alarm fraction at 0x0C bits 14:0} sets status bit 4 (alarm flag) once. Writing 1 to a status bit at 0x14 clears that bit, and a flag being set wins over a clear in the same cycle.
- R7: alarm_irq is high exactly when status bit 4 and interrupt-enable bit 4 (address 0x18) are both set.
- R8: A tick at count 2^47-1 wraps the count to 0 and sets status bit 2, which stops counting until it is cleared.
- R9: While freeze is high, ticks do not change the count.
- R10: A write to the seconds register leaves the fraction unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle 32.768 kHz count strobe |
| freeze | input | 1 | Stop request from the security supervisor |
| non_valid_set | input | 1 | Pulse marking the time as no longer valid |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
Most internal state is visible at the ports within a cycle. A wrong count or carry shows in the seconds and fraction read-back one cycle after the tick that caused it. A run condition decoded wrongly shows as a count that moves, or fails to move, on the next tick. A bad alarm comparison shows as the alarm flag and alarm_irq rising one tick early, one tick late, or more than once. A lock that does not stick shows at the next write to a protected register, as a time value that changed when it should not have.

// File: rtl/rtc_seconds_alarm.sv
module rtc_seconds_alarm #(
  parameter int CNT_W  = 47,
  parameter int FRAC_W = 15,
  parameter int DW     = 32,
  parameter int AW     = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          freeze,
  input  logic          non_valid_set,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          alarm_irq
);
  localparam int SEC_W = CNT_W - FRAC_W;
  localparam logic [2:0] A_SEC = 3'd0, A_FRAC = 3'd1, A_ASEC = 3'd2, A_AFRAC = 3'd3,
                         A_CTRL = 3'd4, A_STAT = 3'd5, A_IEN = 3'd6;
  localparam int B_EN = 3, B_SLK = 17, B_HLK = 18;
  localparam int B_AF = 4, B_OV = 2, B_NV = 1;

  logic [CNT_W-1:0]  count, count_inc;
  logic [SEC_W-1:0]  alm_sec;
  logic [FRAC_W-1:0] alm_frac;
  logic en, slock, hlock, alm_flag, ovf_flag, nv_flag, need_time, alm_ien;
  logic [2:0] widx;
  logic wr_sec, wr_frac, wr_asec, wr_afrac, wr_ctrl, wr_stat, wr_ien;
  logic locked, run, step, carry_out, alarm_hit;

  assign widx     = addr[4:2];
  assign locked   = slock | hlock;
  assign wr_sec   = wr_en && widx == A_SEC  && !locked;
  assign wr_frac  = wr_en && widx == A_FRAC && !locked;
  assign wr_asec  = wr_en && widx == A_ASEC;
  assign wr_afrac = wr_en && widx == A_AFRAC;
  assign wr_ctrl  = wr_en && widx == A_CTRL;
  assign wr_stat  = wr_en && widx == A_STAT;
  assign wr_ien   = wr_en && widx == A_IEN;

  assign run  = en && !freeze && !ovf_flag && !nv_flag && !need_time;
  assign step = tick && run && !wr_sec && !wr_frac;
  assign {carry_out, count_inc} = {1'b0, count} + 1'b1;
  assign alarm_hit = step && !carry_out && count_inc == {alm_sec, alm_frac};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (wr_sec) begin
      count[CNT_W-1:FRAC_W] <= wdata[SEC_W-1:0];
    end else if (wr_frac) begin
      count[FRAC_W-1:0] <= wdata[FRAC_W-1:0];
    end else if (step) begin
      count <= count_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_sec  <= '1;
      alm_frac <= '0;
      alm_ien  <= 1'b0;
    end else begin
      if (wr_asec)  alm_sec  <= wdata[SEC_W-1:0];
      if (wr_afrac) alm_frac <= wdata[FRAC_W-1:0];
      if (wr_ien)   alm_ien  <= wdata[B_AF];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= 1'b0;
      slock <= 1'b0;
      hlock <= 1'b0;
    end else if (wr_ctrl) begin
      if (!hlock) en <= wdata[B_EN];
      slock <= slock | wdata[B_SLK];
      hlock <= hlock | wdata[B_HLK];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_flag  <= 1'b0;
      ovf_flag  <= 1'b0;
      nv_flag   <= 1'b1;
      need_time <= 1'b1;
    end else begin
      if (alarm_hit)                    alm_flag <= 1'b1;
      else if (wr_stat && wdata[B_AF])  alm_flag <= 1'b0;
      if (step && carry_out)            ovf_flag <= 1'b1;
      else if (wr_stat && wdata[B_OV])  ovf_flag <= 1'b0;
      if (non_valid_set)                nv_flag  <= 1'b1;
      else if (wr_stat && wdata[B_NV])  nv_flag  <= 1'b0;
      if (non_valid_set)                need_time <= 1'b1;
      else if (wr_sec)                  need_time <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (widx)
      A_SEC:   rdata[SEC_W-1:0]  = count[CNT_W-1:FRAC_W];
      A_FRAC:  rdata[FRAC_W-1:0] = count[FRAC_W-1:0];
      A_ASEC:  rdata[SEC_W-1:0]  = alm_sec;
      A_AFRAC: rdata[FRAC_W-1:0] = alm_frac;
      A_CTRL: begin
        rdata[B_EN]  = en;
        rdata[B_SLK] = slock;
        rdata[B_HLK] = hlock;
      end
      A_STAT: begin
        rdata[B_AF] = alm_flag;
        rdata[B_OV] = ovf_flag;
        rdata[B_NV] = nv_flag;
      end
      A_IEN:   rdata[B_AF] = alm_ien;
      default: rdata = '0;
    endcase
  end

  assign alarm_irq = alm_flag & alm_ien;
endmodule

module rtc_seconds_alarm_chk #(
  parameter int CNT_W  = 47,
  parameter int FRAC_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             freeze,
  input logic             wr_en,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-FRAC_W-1:0] alm_sec,
  input logic [FRAC_W-1:0] alm_frac,
  input logic             alm_flag,
  input logic             ovf_flag,
  input logic             en,
  input logic             hlock,
  input logic             alarm_irq
);
  // R9
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !wr_en) |=> $stable(count));
  // R8
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> count == '0);
  // R8
  ovf_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !wr_en) |=> $stable(count));
  // R6
  alarm_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alm_flag) |-> count == {alm_sec, alm_frac});
  // R5
  hard_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hlock |=> $stable(en));
  // R5
  hard_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hlock |=> hlock);
  // R4
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !tick) |=> $stable(count));
  // R7
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> alm_flag);
endmodule

bind rtc_seconds_alarm rtc_seconds_alarm_chk #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .freeze(freeze), .wr_en(wr_en),
  .count(count), .alm_sec(alm_sec), .alm_frac(alm_frac), .alm_flag(alm_flag),
  .ovf_flag(ovf_flag), .en(en), .hlock(hlock), .alarm_irq(alarm_irq)
);

// File: tb/rtc_seconds_alarm_bench.sv
module rtc_seconds_alarm_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, freeze = 1'b0, nvs = 1'b0, wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        alarm_irq;
  int errors = 0, checks = 0;
  int unsigned seed = 32'd4711;

  always #2.5 clk = ~clk;

  rtc_seconds_alarm u_rtc_seconds_alarm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .freeze(freeze), .non_valid_set(nvs),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .alarm_irq(alarm_irq)
  );

  // reference model built from the requirements
  logic [46:0] m_cnt;
  logic [31:0] m_asec;
  logic [14:0] m_afrac;
  logic m_en, m_sl, m_hl, m_af, m_ov, m_nv, m_need, m_ien;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_asec <= '1; m_afrac <= '0;
      m_en <= 0; m_sl <= 0; m_hl <= 0; m_af <= 0; m_ov <= 0; m_nv <= 1; m_need <= 1; m_ien <= 0;
    end else begin
      automatic logic lk = m_sl | m_hl;
      automatic logic ws = wr_en && addr == 5'h00 && !lk;
      automatic logic wf = wr_en && addr == 5'h04 && !lk;
      automatic logic go = tick && m_en && !freeze && !m_ov && !m_nv && !m_need && !ws && !wf;
      automatic logic [46:0] nx = m_cnt + 47'd1;
      automatic logic wrap = go && (m_cnt == '1);
      automatic logic hit = go && !wrap && nx == {m_asec, m_afrac};
      automatic logic wst = wr_en && addr == 5'h14;
      if (ws) m_cnt[46:15] <= wdata;
      else if (wf) m_cnt[14:0] <= wdata[14:0];
      else if (go) m_cnt <= nx;
      if (wr_en && addr == 5'h08) m_asec <= wdata;
      if (wr_en && addr == 5'h0C) m_afrac <= wdata[14:0];
      if (wr_en && addr == 5'h18) m_ien <= wdata[4];
      if (wr_en && addr == 5'h10) begin
        if (!m_hl) m_en <= wdata[3];
        m_sl <= m_sl | wdata[17];
        m_hl <= m_hl | wdata[18];
      end
      if (hit) m_af <= 1; else if (wst && wdata[4]) m_af <= 0;
      if (wrap) m_ov <= 1; else if (wst && wdata[2]) m_ov <= 0;
      if (nvs) m_nv <= 1; else if (wst && wdata[1]) m_nv <= 0;
      if (nvs) m_need <= 1; else if (ws) m_need <= 0;
    end
  end

  function automatic logic [31:0] exp_read(input logic [4:0] a);
    case (a)
      5'h00: return m_cnt[46:15];
      5'h04: return {17'd0, m_cnt[14:0]};
      5'h08: return m_asec;
      5'h0C: return {17'd0, m_afrac};
      5'h10: return (32'(m_hl) << 18) | (32'(m_sl) << 17) | (32'(m_en) << 3);
      5'h14: return (32'(m_af) << 4) | (32'(m_ov) << 2) | (32'(m_nv) << 1);
      5'h18: return 32'(m_ien) << 4;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input string tag, input logic [4:0] a, input logic [31:0] exp);
    addr = a; #0.5;
    chk(tag, rdata, exp);
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    wr_en = 0; tick = 0; nvs = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d; cyc();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin tick = 1; cyc(); end
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1; rst_n = 1;
    // R1 reset state
    rd("R1 sec", 5'h00, 0); rd("R1 frac", 5'h04, 0);
    rd("R1 asec", 5'h08, 32'hFFFF_FFFF); rd("R1 afrac", 5'h0C, 0);
    rd("R1 ctrl", 5'h10, 0); rd("R1 stat", 5'h14, 32'h2); rd("R1 ien", 5'h18, 0);
    chk("R1 irq", alarm_irq, 0);
    // R2 non-valid holds the count
    wr(5'h10, 32'h8); ticks(4);
    rd("R2 nv holds", 5'h04, 0);
    // R3 time write needed after clearing non-valid
    wr(5'h14, 32'h2); ticks(4);
    rd("R3 need time", 5'h04, 0);
    wr(5'h04, 0); wr(5'h00, 5); ticks(3);
    rd("R3 resumes", 5'h04, 3);
    // R4 carry into seconds
    wr(5'h04, 32'h7FFF); ticks(1);
    rd("R4 carry sec", 5'h00, 6); rd("R4 carry frac", 5'h04, 0);
    tick = 1; wr(5'h04, 32'h100);
    rd("R4 write beats tick", 5'h04, 32'h100);
    // R10 seconds write keeps fraction
    wr(5'h00, 10);
    rd("R10 frac kept", 5'h04, 32'h100); rd("R10 sec", 5'h00, 10);
    // R6/R7 alarm
    wr(5'h08, 10); wr(5'h0C, 32'h103); wr(5'h18, 32'h10); ticks(2);
    rd("R6 not yet", 5'h14, 0); chk("R7 irq low", alarm_irq, 0);
    ticks(1);
    rd("R6 flag set", 5'h14, 32'h10); chk("R7 irq high", alarm_irq, 1);
    ticks(2); wr(5'h14, 32'h10); ticks(3);
    rd("R6 fires once", 5'h14, 0);
    wr(5'h00, 10); wr(5'h04, 32'h102); ticks(1);
    wr(5'h18, 0);
    rd("R6 refire", 5'h14, 32'h10); chk("R7 masked", alarm_irq, 0);
    wr(5'h14, 32'h10);
    // R9 freeze
    freeze = 1; ticks(5); freeze = 0;
    rd("R9 frozen", 5'h04, 32'h103);
    // R8 overflow
    wr(5'h00, 32'hFFFF_FFFF); wr(5'h04, 32'h7FFF); ticks(1);
    rd("R8 wrap sec", 5'h00, 0); rd("R8 wrap frac", 5'h04, 0); rd("R8 flag", 5'h14, 32'h4);
    ticks(3); rd("R8 stopped", 5'h04, 0);
    wr(5'h14, 32'h4); ticks(1); rd("R8 resumes", 5'h04, 1);
    // R2 non_valid_set pulse
    nvs = 1; cyc(); ticks(3);
    rd("R2 nv set", 5'h14, 32'h2); rd("R2 nv stop", 5'h04, 1);
    wr(5'h14, 32'h2); wr(5'h00, 32'h20);
    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      automatic int unsigned r = $urandom(seed) % 100;
      seed = seed + 32'd7919;
      freeze = ($urandom % 16) == 0;
      if (r < 60) tick = 1;
      else if (r < 66) begin wr_en = 1; addr = 5'h08; wdata = m_cnt[46:15]; end
      else if (r < 72) begin wr_en = 1; addr = 5'h0C; wdata = 32'(m_cnt[14:0] + ($urandom % 8)); end
      else if (r < 76) begin wr_en = 1; addr = 5'h14; wdata = $urandom & 32'h16; end
      else if (r < 79) begin wr_en = 1; addr = 5'h18; wdata = $urandom; end
      else if (r < 81) begin wr_en = 1; addr = 5'h00; wdata = $urandom % 64; end
      else if (r < 82) nvs = 1;
      else if (r < 84) begin wr_en = 1; addr = 5'h10; wdata = 32'h8; end
      else if (r < 86) begin wr_en = 1; addr = 5'h04; wdata = 32'h7FFE; tick = 1; end
      cyc();
      if (i % 50 == 0) begin
        for (int k = 0; k < 7; k++) rd("R6 random regs", 5'(k * 4), exp_read(5'(k * 4)));
        chk("R7 random irq", alarm_irq, m_af & m_ien);
      end
    end
    freeze = 0;
    // R5 locks
    wr(5'h14, 32'h16); wr(5'h10, 32'h8); wr(5'h00, 100);
    wr(5'h10, 32'h2_0008); wr(5'h00, 200); wr(5'h04, 32'h55);
    rd("R5 soft blocks sec", 5'h00, 100); rd("R5 soft blocks frac", 5'h04, exp_read(5'h04));
    wr(5'h10, 32'h0);
    rd("R5 soft sticky", 5'h10, 32'h2_0000);
    wr(5'h10, 32'h4_0008); wr(5'h10, 32'h0);
    rd("R5 hard pins en", 5'h10, 32'h6_0008);
    rd("R5 final sec", 5'h00, 100);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule